// File: doc/BRIEF.md
# Time-Break Event Flag Generator

This block stamps an external timing event onto a stream of output samples. A raw, asynchronous event line is synchronized and watched for a rising edge. The edge arms a countdown, and the countdown advances once per output-sample strobe, not once per clock. When the programmed number of samples has gone by, a single flag bit is placed in the status byte of the next output word. This happens on every channel whose enable bit is set.

The countdown length is written through a small register port. It lets the flag cancel the group delay of the downstream digital filters, so the flagged sample is the one measured at the moment of the event. The flag clears itself at the following sample. Only one event is tracked at a time, and any further edge is ignored until the pending flag has been issued.

Top module: `tbreak_flagger`

## Requirements
- R1: Only a low-to-high transition of `evt_async` arms the block. The line must be presented at least three clock cycles before a strobe for that strobe to count. A line that stays high never re-arms it.
- R2: The countdown advances only on cycles where `smp_stb` is high. The number of clock cycles between strobes has no effect on which sample is flagged.
- R3: The delay register is `DLY_W` (16) bits wide, resets to 0 and is written when `cfg_we` is high and `cfg_addr` equals 0x29. Writes to any other address leave it unchanged.
- R4: With a delay of 0, the flag appears on the first strobe after the edge is armed.
- R5: With a delay of N, N strobes pass without a flag, and strobe number N+1 (0-based index N) carries the flag.
- R6: After each strobe, `mark_o` holds the status flag of the sample emitted at that strobe. A flag lasts for exactly one sample and reads 0 again after the next strobe.
- R7: At the flag strobe, `mark_o` bit i equals `chan_en` bit i as sampled at that strobe. A disabled channel always reads 0.
- R8: A rising edge that arrives while a countdown is pending is ignored. It neither restarts the count nor produces a second flag.
- R9: A delay write during a countdown does not change the pending event. It applies from the next armed event on.
- R10: Reset clears the pending event, the counter and `mark_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_async | input | 1 | Raw asynchronous time-break event line |
| smp_stb | input | 1 | One-cycle strobe per output sample |
| chan_en | input | NCH | Per-channel enable mask |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | REG_AW | Register write address |
| cfg_wdata | input | DLY_W | Register write data |
| mark_o | output | NCH | Per-channel status flag for the current output sample |

## Verification
The main function is swept over every delay from 0 to 9 against all sixteen enable masks of a four-channel build. The strobe spacing changes with the mask. An error in the count, an off-by-one between delay zero and N, or a count driven by clocks instead of samples each shift the flag to a different strobe index. The event line is kept high past the flag, which separates true edge detection from level sensing. Directed cases then pulse a second edge mid-count, rewrite the delay mid-count, write a neighbouring address, change the mask just before the flag, and reset during a countdown. Each of these shows whether that stimulus leaked into the pending event.

// File: rtl/tbf_pkg.sv
package tbf_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_COUNT = 1'b1
  } tbf_state_e;
endpackage

// File: rtl/tbf_rstsync.sv
module tbf_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tbf_sync.sv
module tbf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_async,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= evt_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign edge_o = lvl & ~prev_q;

  // An edge pulse never lasts more than one cycle (level does not retrigger).
  assert_edge_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/tbf_cfg.sv
module tbf_cfg #(
  parameter int unsigned        REG_AW   = 8,
  parameter int unsigned        DLY_W    = 16,
  parameter logic [REG_AW-1:0]  DLY_ADDR = 'h29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DLY_W-1:0]  cfg_wdata,
  output logic [DLY_W-1:0]  dly_o
);
  logic             hit;
  logic [DLY_W-1:0] dly_q;
  logic [DLY_W-1:0] dly_d;

  assign hit = cfg_we && (cfg_addr == DLY_ADDR);

  always_comb begin
    dly_d = dly_q;
    if (hit) dly_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else        dly_q <= dly_d;
  end

  assign dly_o = dly_q;

  assert_cfg_other_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we || cfg_addr != DLY_ADDR) |=> $stable(dly_o));
endmodule

// File: rtl/tbf_count.sv
module tbf_count
  import tbf_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic             stb_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             fire_o
);
  tbf_state_e       st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             armed;
  logic             zero;

  assign armed  = (st_q == ST_COUNT);
  assign zero   = (cnt_q == '0);
  assign fire_o = armed && stb_i && zero;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (edge_i) begin
          st_d  = ST_COUNT;
          cnt_d = dly_i;
        end
      end
      ST_COUNT: begin
        if (stb_i) begin
          if (zero) st_d  = ST_IDLE;
          else      cnt_d = cnt_q - DLY_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // Arming latches the delay value present at that moment.
  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && edge_i) |=> (armed && cnt_q == $past(dly_i)));
  // Without a strobe the count and pending state hold, whatever the edge does.
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !stb_i) |=> (armed && $stable(cnt_q)));
  // A second edge during a countdown never reloads the counter.
  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && edge_i && stb_i && !zero) |=> (cnt_q == $past(cnt_q) - DLY_W'(1)));
  // Issuing the flag releases the pending event.
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !armed);
endmodule

// File: rtl/tbf_mark.sv
module tbf_mark #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stb_i,
  input  logic           fire_i,
  input  logic [NCH-1:0] en_i,
  output logic [NCH-1:0] mark_o
);
  logic [NCH-1:0] mark_q, mark_d;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      always_comb begin
        mark_d[c] = mark_q[c];
        if (stb_i) mark_d[c] = fire_i & en_i[c];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mark_q[c] <= 1'b0;
        else        mark_q[c] <= mark_d[c];
      end
    end
  endgenerate

  assign mark_o = mark_q;

  assert_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i |=> ((mark_o & ~$past(en_i)) == '0));
  assert_per_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(mark_o));
endmodule

// File: rtl/tbreak_flagger.sv
module tbreak_flagger #(
  parameter int unsigned       NCH      = 8,
  parameter int unsigned       DLY_W    = 16,
  parameter int unsigned       REG_AW   = 8,
  parameter logic [REG_AW-1:0] DLY_ADDR = 'h29,
  parameter int unsigned       SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_async,
  input  logic              smp_stb,
  input  logic [NCH-1:0]    chan_en,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DLY_W-1:0]  cfg_wdata,
  output logic [NCH-1:0]    mark_o
);
  localparam int unsigned RST_N = 2;

  logic             rst_q_n;
  logic             evt_edge;
  logic             fire;
  logic [DLY_W-1:0] dly;

  tbf_rstsync #(.STAGES(RST_N)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_q_n)
  );

  tbf_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .evt_async(evt_async), .edge_o(evt_edge)
  );

  tbf_cfg #(.REG_AW(REG_AW), .DLY_W(DLY_W), .DLY_ADDR(DLY_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_q_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dly_o(dly)
  );

  tbf_count #(.DLY_W(DLY_W)) u_cnt (
    .clk(clk), .rst_n(rst_q_n), .edge_i(evt_edge), .stb_i(smp_stb),
    .dly_i(dly), .fire_o(fire)
  );

  tbf_mark #(.NCH(NCH)) u_mark (
    .clk(clk), .rst_n(rst_q_n), .stb_i(smp_stb), .fire_i(fire),
    .en_i(chan_en), .mark_o(mark_o)
  );

  // Reset leaves no flag behind.
  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_q_n |-> (mark_o == '0));
endmodule

// File: tb/sim_tbreak_flagger.sv
module sim_tbreak_flagger;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           evt_async = 1'b0;
  logic           smp_stb = 1'b0;
  logic [NCH-1:0] chan_en = '0;
  logic           cfg_we = 1'b0;
  logic [7:0]     cfg_addr = '0;
  logic [15:0]    cfg_wdata = '0;
  logic [NCH-1:0] mark_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tbreak_flagger #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_async(evt_async), .smp_stb(smp_stb),
    .chan_en(chan_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mark_o(mark_o)
  );

  task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: mark_o=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One strobe; checks the flag of the sample emitted at it, then idles gap-1 cycles.
  task automatic stb_chk(input string req, input logic [NCH-1:0] exp, input int gap);
    @(negedge clk); smp_stb = 1'b1;
    @(negedge clk); smp_stb = 1'b0;
    chk(req, mark_o, exp);
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic rise();
    @(negedge clk); evt_async = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic fall();
    @(negedge clk); evt_async = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset state", mark_o, '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 after release", mark_o, '0);

    // R3: delay reset value is 0, so a first event flags the next strobe.
    chan_en = 4'hF;
    rise();
    stb_chk("R3 reset delay 0", 4'hF, 2);
    stb_chk("R6 cleared", 4'h0, 2);
    fall();

    // Sweep: delay 0..9, all masks, varied strobe spacing (R2, R4, R5, R6, R1, R7).
    for (int d = 0; d < 10; d++) begin
      for (int e = 0; e < 16; e++) begin
        wr(8'h29, 16'(d));
        chan_en = e[NCH-1:0];
        rise();
        for (int i = 0; i < d + 3; i++) begin
          if (i == d)
            stb_chk(d == 0 ? "R4 flag at first strobe" : "R5 R2 flag at strobe N",
                    e[NCH-1:0], 1 + (e % 3));
          else if (i > d)
            stb_chk("R6 R1 no flag after issue with line high", '0, 1 + (e % 3));
          else
            stb_chk("R5 R2 no flag before N", '0, 1 + (e % 3));
        end
        fall();
      end
    end

    // R8: second edge mid-count ignored.
    wr(8'h29, 16'd5);
    chan_en = 4'b1010;
    rise();
    stb_chk("R8 pre", '0, 2);
    stb_chk("R8 pre", '0, 2);
    fall();
    rise();
    for (int i = 2; i < 5; i++) stb_chk("R8 no restart", '0, 2);
    stb_chk("R8 original flag", 4'b1010, 2);
    for (int i = 0; i < 6; i++) stb_chk("R8 no second flag", '0, 2);
    fall();

    // R9: rewrite during countdown affects the next event only.
    wr(8'h29, 16'd3);
    chan_en = 4'hF;
    rise();
    stb_chk("R9 pre", '0, 1);
    wr(8'h29, 16'd0);
    stb_chk("R9 pre", '0, 1);
    stb_chk("R9 pre", '0, 1);
    stb_chk("R9 old delay kept", 4'hF, 1);
    fall();
    rise();
    stb_chk("R9 new delay used", 4'hF, 1);
    fall();

    // R3: write to another address ignored.
    wr(8'h28, 16'd2);
    wr(8'h2A, 16'd4);
    rise();
    stb_chk("R3 other address ignored", 4'hF, 1);
    stb_chk("R3 cleared", '0, 1);
    fall();

    // R7: mask sampled at the flag strobe.
    wr(8'h29, 16'd2);
    chan_en = 4'hF;
    rise();
    stb_chk("R7 pre", '0, 2);
    stb_chk("R7 pre", '0, 2);
    chan_en = 4'b0110;
    stb_chk("R7 mask at flag strobe", 4'b0110, 2);
    chan_en = 4'h0;
    rise();
    fall();
    rise();
    stb_chk("R7 pre", '0, 2);
    stb_chk("R7 pre", '0, 2);
    stb_chk("R7 all disabled", '0, 2);
    fall();

    // R10: reset during a countdown drops the pending event.
    chan_en = 4'hF;
    wr(8'h29, 16'd3);
    rise();
    stb_chk("R10 pre", '0, 2);
    @(negedge clk); evt_async = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 flag cleared in reset", mark_o, '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 6; i++) stb_chk("R10 pending dropped", '0, 2);
    rise();
    stb_chk("R10 R3 delay back to 0", 4'hF, 2);
    fall();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule